// File: doc/BRIEF.md
# Burst Mode Synchronous SRAM

A clock-synchronous single-port memory that serves a run of four consecutive words after one random access. The access starts when the address-load strobe is sampled high at a clock edge. That edge captures the start address, the transfer direction and the count order. On a write, the same edge also captures the first data word. Each further word then moves at one word per clock, with the addresses made by an internal burst counter. A cache controller uses this block to refill a four-word line at the rate that an interleaved main memory delivers it. The same block also serves whole lines back to a processor.

The counter has two orders. In linear order the two low address bits count up modulo four and wrap inside the aligned four-word block. In interleaved order they equal the starting low bits XOR the beat number. In both orders the upper address bits do not change during a burst. After the fourth beat the block goes idle until the next strobe. A strobe that arrives during a burst abandons that burst and starts a new access.

Top module: `burst_sram`

## Requirements
- R1: While rst_ni is low, and after it rises until the first load, no burst is active and rdata_o is all zeros. A reset during a burst ends that burst at once.
- R2: At a clock edge with load_i high, the block captures addr_i, write_i (1 = write, 0 = read), order_i (0 = linear, 1 = interleaved) and wdata_i. Beat 0 addresses the captured addr_i.
- R3: On a read burst, rdata_o shows the word at beat b's address during the cycle after the b-th edge following the load edge (beat 0 in the cycle directly after the load edge). So the first word arrives within the second cycle of the access, and each later word one cycle after the one before it.
- R4: On a write burst, the word captured at the load edge is written to beat 0's address at the next edge. At each edge that ends a write beat, the block stores the held word and captures wdata_i as the word for the next beat.
- R5: In linear order, beat b addresses {start[AW-1:2], (start[1:0] + b) mod 4}.
- R6: In interleaved order, beat b addresses {start[AW-1:2], start[1:0] XOR b}.
- R7: A burst covers exactly four beats. After the fourth, rdata_o is zero and the array is not written until the next load, whatever wdata_i does.
- R8: A load during a burst starts a new access at that edge. The write that the abandoned beat would have made at that edge is not performed.
- R9: Changes on write_i, order_i and addr_i after the load edge have no effect on the running burst.
- R10: rdata_o is zero during every write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Address-load strobe that starts an access |
| write_i | input | 1 | Direction, sampled at load: 1 write, 0 read |
| order_i | input | 1 | Count order, sampled at load: 0 linear, 1 interleaved |
| addr_i | input | AW (8) | Start address |
| wdata_i | input | DW (16) | Write data word |
| rdata_o | output | DW (16) | Read data, zero when no read beat is active |

## Verification
The assertions assume that the inputs change only away from the rising edge. They also assume that the block has come out of reset before the first load, because the array itself is never reset. The bench drives every input on the falling edge and starts a burst only after reset is released. It reads back only words that it has already written, so every expected value comes from its own memory model. During every burst it scrambles write_i, order_i and addr_i, so the rule that these are sampled only at the load edge is tested all the time.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_sram_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned LW = $clog2(BURST_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          write_i,
  input  logic          order_i,
  output logic          active_o,
  output logic [LW-1:0] beat_o,
  output dir_e          dir_o,
  output order_e        order_o,
  output logic          wr_en_o,
  output logic          step_o
);

  localparam logic [LW-1:0] LAST_BEAT = LW'(BURST_LEN - 1);

  logic          active_q;
  logic [LW-1:0] beat_q;
  dir_e          dir_q;
  order_e        order_q;
  logic          last_beat;

  assign last_beat = (beat_q == LAST_BEAT);
  // a load at the same edge takes precedence and drops the pending beat
  assign step_o    = active_q && !load_i;
  assign wr_en_o   = step_o && (dir_q == DIR_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      dir_q    <= DIR_READ;
      order_q  <= ORD_LINEAR;
    end else if (load_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      dir_q    <= dir_e'(write_i);
      order_q  <= order_e'(order_i);
    end else if (active_q) begin
      if (last_beat) begin
        active_q <= 1'b0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign dir_o    = dir_q;
  assign order_o  = order_q;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned LW = $clog2(BURST_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  order_e        order_i,
  input  logic [LW-1:0] beat_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] base_q;
  logic [LW-1:0] low_lin;
  logic [LW-1:0] low_ilv;
  logic [LW-1:0] low_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
    end
  end

  assign low_lin = base_q[LW-1:0] + beat_i;
  assign low_ilv = base_q[LW-1:0] ^ beat_i;
  assign low_sel = (order_i == ORD_INTERLEAVE) ? low_ilv : low_lin;

  generate
    if (AW > LW) begin : g_hi
      assign addr_o = {base_q[AW-1:LW], low_sel};
    end else begin : g_lo
      assign addr_o = low_sel;
    end
  endgenerate

endmodule

// File: rtl/burst_wreg.sv
module burst_wreg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] wdata_o
);

  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (capture_i) begin
      data_q <= wdata_i;
    end
  end

  assign wdata_o = data_q;

endmodule

// File: rtl/burst_array.sv
module burst_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  // asynchronous read: data appears within the access cycle
  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned LW = $clog2(BURST_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          write_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic          active;
  logic [LW-1:0] beat;
  dir_e          dir_q;
  order_e        order_q;
  logic          wr_en;
  logic          step;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] wreg;
  logic [DW-1:0] arr_rdata;
  logic          wcap;

  burst_seq #(.BURST_LEN(BURST_LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .write_i (write_i),
    .order_i (order_i),
    .active_o(active),
    .beat_o  (beat),
    .dir_o   (dir_q),
    .order_o (order_q),
    .wr_en_o (wr_en),
    .step_o  (step)
  );

  burst_addr_gen #(.AW(AW), .BURST_LEN(BURST_LEN)) u_agen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .addr_i (addr_i),
    .order_i(order_q),
    .beat_i (beat),
    .addr_o (cur_addr)
  );

  assign wcap = load_i || wr_en;

  burst_wreg #(.DW(DW)) u_wreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(wcap),
    .wdata_i  (wdata_i),
    .wdata_o  (wreg)
  );

  burst_array #(.AW(AW), .DW(DW)) u_arr (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .addr_i (cur_addr),
    .wdata_i(wreg),
    .rdata_o(arr_rdata)
  );

  assign rdata_o = (active && dir_q == DIR_READ) ? arr_rdata : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned LW = $clog2(BURST_LEN)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          active,
  input logic [LW-1:0] beat,
  input dir_e          dir_q,
  input order_e        order_q,
  input logic [AW-1:0] cur_addr
);

  localparam logic [LW-1:0] LAST_BEAT = LW'(BURST_LEN - 1);

  logic mid_step;
  assign mid_step = active && !load_i && (beat != LAST_BEAT);

  // R2
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cur_addr == $past(addr_i)));

  // R8
  load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (active && beat == '0));

  // R7
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !load_i && beat == LAST_BEAT) |=> !active);

  // R5
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_step && order_q == ORD_LINEAR) |=>
      (cur_addr[LW-1:0] == LW'($past(cur_addr[LW-1:0]) + 1'b1)));

  // R6
  ilv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_step && order_q == ORD_INTERLEAVE) |=>
      (cur_addr[LW-1:0] == ($past(cur_addr[LW-1:0]) ^ $past(beat) ^ beat)));

  // R5
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_step |=> $stable(cur_addr[AW-1:LW]));

  // R10
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active || dir_q == DIR_WRITE) |-> (rdata_o == '0));

endmodule

bind burst_sram burst_sram_chk #(.AW(AW), .DW(DW), .BURST_LEN(BURST_LEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .active  (active),
  .beat    (beat),
  .dir_q   (dir_q),
  .order_q (order_q),
  .cur_addr(cur_addr)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic          write_i = 1'b0;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] model [1 << AW];

  always #5 clk = ~clk;

  burst_sram uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .write_i(write_i),
    .order_i(order_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  // {order, start address, data seed}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'h10, 16'hA000},
    {1'b0, 8'h23, 16'hB100},
    {1'b1, 8'h31, 16'hC200},
    {1'b1, 8'h46, 16'hD300},
    {1'b0, 8'hFE, 16'hE400},
    {1'b1, 8'h8B, 16'h1500},
    {1'b0, 8'h55, 16'h2600},
    {1'b1, 8'hC0, 16'h3700}
  };

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] s, logic ord, int b);
    logic [1:0] lo;
    lo = ord ? (s[1:0] ^ 2'(b)) : (s[1:0] + 2'(b));
    return {s[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] word(logic [DW-1:0] seed, int b);
    return seed + DW'(b * 16'h1111);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // full burst; write_i, order_i and addr_i are scrambled after the load edge (R9)
  task automatic burst(bit wr, bit ord, logic [AW-1:0] a, logic [DW-1:0] seed, string req);
    @(negedge clk);
    load_i = 1'b1; write_i = wr; order_i = ord; addr_i = a; wdata_i = seed;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      load_i = 1'b0; write_i = ~wr; order_i = ~ord; addr_i = ~a;
      wdata_i = word(seed, b + 1);
      if (wr) begin
        check({req, " R10"}, rdata_o, '0);
        model[beat_addr(a, ord, b)] = word(seed, b);
      end else begin
        check({req, " R9"}, rdata_o, model[beat_addr(a, ord, b)]);
      end
    end
    @(negedge clk);
    check("R7", rdata_o, '0);
    write_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rdata_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", rdata_o, '0);

    // vector table: write burst, then read back with other order and start
    for (int i = 0; i < 8; i++) begin
      logic          ord;
      logic [AW-1:0] a;
      ord = VEC[i][24];
      a   = VEC[i][23:16];
      burst(1'b1, ord, a, VEC[i][15:0], ord ? "R4 R2 R6" : "R4 R2 R5");
      burst(1'b0, ~ord, {a[AW-1:2], a[1:0] + 2'd1}, '0, ord ? "R3 R5" : "R3 R6");
    end

    // idle edges with moving write data must not touch the array (R7)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wdata_i = 16'hDEAD + DW'(i);
    end
    burst(1'b0, 1'b0, 8'h10, '0, "R7 R3");

    // abort a write burst with a load after its first stored beat (R8)
    burst(1'b1, 1'b0, 8'h40, 16'h1000, "R4");
    @(negedge clk);
    load_i = 1'b1; write_i = 1'b1; order_i = 1'b0; addr_i = 8'h40; wdata_i = 16'h5550;
    @(negedge clk);
    load_i = 1'b0; wdata_i = 16'h5551;
    @(negedge clk);
    model[8'h40] = 16'h5550;
    load_i = 1'b1; write_i = 1'b0; order_i = 1'b1; addr_i = 8'h42; wdata_i = 16'h7777;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      load_i = 1'b0; write_i = 1'b1;
      check("R8", rdata_o, model[beat_addr(8'h42, 1'b1, b)]);
    end
    @(negedge clk);
    check("R8 R7", rdata_o, '0);

    // reset in the middle of a read burst (R1)
    @(negedge clk);
    load_i = 1'b1; write_i = 1'b0; order_i = 1'b0; addr_i = 8'h10;
    @(negedge clk);
    load_i = 1'b0;
    check("R3", rdata_o, model[8'h10]);
    rst_ni = 1'b0;
    #1;
    check("R1", rdata_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", rdata_o, '0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule